// File: doc/BRIEF.md
# Low-Power Mode Controller

This block decides whether a powered device runs in its normal wake state or rests in one of two low-power states, light sleep and ultra-low-power. Three active-low control inputs steer it. A falling edge on the sleep request moves it out of wake, and the level of the ultra-low-power select at that moment picks which of the two rest states it enters. A falling edge on the wake request brings it back.

The controller produces only on/off control waveforms. The regulator enables are high while the device is awake. In either rest state an indicator LED drive blinks at a fixed rate with a short on-time. In the ultra-low-power state a keep-alive load enable also switches on and off slowly, so the supply still sees enough current to keep the link powered.

All timing is counted in ticks from a prescaler on the system clock. Every period is a parameter, so the block can be sized for real time or shortened for simulation. A power-good qualifier from the power-path sequencer overrides everything else. While it is low, the controller is held in wake and its timers are cleared.

Top module: `lpm_ctrl`

## Requirements
- R1: From wake with power-good high, a falling edge on `sleepReqN` enters light sleep if `ulpSelN` is 1 and ultra-low-power if `ulpSelN` is 0. The value of `ulpSelN` is taken in the same synchronised cycle as the edge. The change is visible at the outputs after the third rising clock edge that follows the input falling.
- R2: A falling edge on `sleepReqN` while the controller is in either low-power state has no effect.
- R3: A falling edge on `wakeReqN` returns the controller from either low-power state to wake. The same edge while in wake has no effect.
- R4: `buckEn` and `ldoEn` are 1 exactly when the controller is in wake and `pwrGood` is 1.
- R5: In both low-power states, `ledOn` is 1 for the first LED_ON ticks after entry and 0 for the rest of each LED_PERIOD-tick period, repeating. One tick is TICK_DIV clock cycles. `ledOn` is 0 in wake.
- R6: In the ultra-low-power state, `keepAliveEn` is 1 for KA_ON ticks starting at entry and then 0 for KA_OFF ticks, repeating. It is 0 in every other state.
- R7: While `pwrGood` is 0, the enables, `ledOn` and `keepAliveEn` are all 0. The controller returns to wake at the next clock edge, and every timer restarts from zero. Sleep edges seen during this time are ignored.
- R8: After reset the controller is in wake with `ledOn` and `keepAliveEn` at 0. The input synchronisers reset to the idle-high level, so inputs held high through reset release cause no transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwrGood | input | 1 | Power-path qualifier, synchronous to clk |
| sleepReqN | input | 1 | Active-low sleep request, asynchronous |
| wakeReqN | input | 1 | Active-low wake request, asynchronous, idle high |
| ulpSelN | input | 1 | Low selects ultra-low-power on the next sleep edge, idle high |
| buckEn | output | 1 | Buck converter enable |
| ldoEn | output | 1 | Linear regulator enable |
| ledOn | output | 1 | Indicator LED drive gate |
| keepAliveEn | output | 1 | Keep-alive load enable |

## Verification
A wrong state shows up at the ports within one clock after the state register settles. A stray low-power state drops `buckEn`. Confusing light sleep with ultra-low-power puts `keepAliveEn` in the wrong state from the first cycle of entry, because that waveform begins in its on phase. A timer that was not cleared on entry or on power-good loss shifts the phase of the LED and keep-alive waveforms. The bench compares those waveforms against the expected sequence every cycle, starting from the first cycle after entry. A lost or extra edge detection shows up as an enable level mismatch three cycles after the input moves.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [1:0] {
    ST_WAKE  = 2'd0,
    ST_SLEEP = 2'd1,
    ST_ULP   = 2'd2
  } lpmState_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic run;      // a low-power state is active and power is good
    logic ulpMode;  // the active state is ultra-low-power
  } lpmStrobe_t;

  localparam int NUM_IN   = 3;
  localparam int IN_SLEEP = 0;
  localparam int IN_WAKE  = 1;
  localparam int IN_ULP   = 2;

endpackage

// File: rtl/lpm_sync.sv
module lpm_sync #(
  parameter int          WIDTH     = 3,
  parameter logic [WIDTH-1:0] EDGE_MASK = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] rawN,
  output logic [WIDTH-1:0] syncOut
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic stage1, stage2;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stage1 <= 1'b1;
        stage2 <= 1'b1;
      end else begin
        stage1 <= rawN[i];
        stage2 <= stage1;
      end
    end

    if (EDGE_MASK[i]) begin : g_edge
      logic prevLvl;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) prevLvl <= 1'b1;
        else       prevLvl <= stage2;
      end
      assign syncOut[i] = prevLvl & ~stage2;
    end else begin : g_level
      assign syncOut[i] = stage2;
    end
  end

endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwrGood,
  input  logic       sleepFall,
  input  logic       wakeFall,
  input  logic       ulpSelLvlN,
  output lpmState_e  curState,
  output lpmStrobe_t strobe,
  output logic       buckEn,
  output logic       ldoEn
);

  lpmState_e nxtState;

  always_comb begin
    nxtState = curState;
    if (!pwrGood) begin
      nxtState = ST_WAKE;
    end else begin
      unique case (curState)
        ST_WAKE:  if (sleepFall) nxtState = ulpSelLvlN ? ST_SLEEP : ST_ULP;
        ST_SLEEP,
        ST_ULP:   if (wakeFall)  nxtState = ST_WAKE;
        default:  nxtState = ST_WAKE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curState <= ST_WAKE;
    else       curState <= nxtState;
  end

  always_comb begin
    strobe.run     = pwrGood && (curState != ST_WAKE);
    strobe.ulpMode = (curState == ST_ULP);
    buckEn         = pwrGood && (curState == ST_WAKE);
    ldoEn          = buckEn;
  end

endmodule

// File: rtl/lpm_wave.sv
module lpm_wave
  import lpm_pkg::*;
#(
  parameter int TICK_DIV   = 100,
  parameter int LED_PERIOD = 4000,
  parameter int LED_ON     = 1000,
  parameter int KA_ON      = 88000,
  parameter int KA_OFF     = 237000
) (
  input  logic       clk,
  input  logic       rstN,
  input  lpmStrobe_t strobe,
  output logic       ledWave,
  output logic       kaWave
);

  localparam int KA_MAX = (KA_ON > KA_OFF) ? KA_ON : KA_OFF;
  localparam int LED_W  = (LED_PERIOD > 1) ? $clog2(LED_PERIOD) : 1;
  localparam int KA_W   = (KA_MAX > 1) ? $clog2(KA_MAX) : 1;
  localparam logic [LED_W-1:0] LED_LAST = LED_W'(LED_PERIOD - 1);
  localparam logic [LED_W-1:0] LED_ONC  = LED_W'(LED_ON);
  localparam logic [KA_W-1:0]  KA_ONL   = KA_W'(KA_ON - 1);
  localparam logic [KA_W-1:0]  KA_OFFL  = KA_W'(KA_OFF - 1);

  logic tick;

  // prescaler variant chosen by the divide ratio
  if (TICK_DIV > 1) begin : g_pre
    localparam int PRE_W = $clog2(TICK_DIV);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
    logic [PRE_W-1:0] preCnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                preCnt <= '0;
      else if (!strobe.run)     preCnt <= '0;
      else if (preCnt == PRE_LAST) preCnt <= '0;
      else                      preCnt <= preCnt + 1'b1;
    end
    assign tick = strobe.run && (preCnt == PRE_LAST);
  end else begin : g_nopre
    assign tick = strobe.run;
  end

  logic [LED_W-1:0] ledCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              ledCnt <= '0;
    else if (!strobe.run)   ledCnt <= '0;
    else if (tick)          ledCnt <= (ledCnt == LED_LAST) ? '0 : ledCnt + 1'b1;
  end

  logic [KA_W-1:0] kaCnt;
  logic            kaPhaseOn;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kaCnt     <= '0;
      kaPhaseOn <= 1'b1;
    end else if (!strobe.run || !strobe.ulpMode) begin
      kaCnt     <= '0;
      kaPhaseOn <= 1'b1;
    end else if (tick) begin
      if (kaPhaseOn && kaCnt == KA_ONL) begin
        kaCnt     <= '0;
        kaPhaseOn <= 1'b0;
      end else if (!kaPhaseOn && kaCnt == KA_OFFL) begin
        kaCnt     <= '0;
        kaPhaseOn <= 1'b1;
      end else begin
        kaCnt <= kaCnt + 1'b1;
      end
    end
  end

  assign ledWave = strobe.run && (ledCnt < LED_ONC);
  assign kaWave  = strobe.run && strobe.ulpMode && kaPhaseOn;

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int TICK_DIV   = 100,
  parameter int LED_PERIOD = 4000,
  parameter int LED_ON     = 1000,
  parameter int KA_ON      = 88000,
  parameter int KA_OFF     = 237000
) (
  input  logic clk,
  input  logic rstN,
  input  logic pwrGood,
  input  logic sleepReqN,
  input  logic wakeReqN,
  input  logic ulpSelN,
  output logic buckEn,
  output logic ldoEn,
  output logic ledOn,
  output logic keepAliveEn
);

  localparam logic [NUM_IN-1:0] EDGE_BITS = NUM_IN'((1 << IN_SLEEP) | (1 << IN_WAKE));

  logic [NUM_IN-1:0] rawN;
  logic [NUM_IN-1:0] syncOut;
  lpmState_e         curState;
  lpmStrobe_t        strobe;

  assign rawN[IN_SLEEP] = sleepReqN;
  assign rawN[IN_WAKE]  = wakeReqN;
  assign rawN[IN_ULP]   = ulpSelN;

  lpm_sync #(.WIDTH(NUM_IN), .EDGE_MASK(EDGE_BITS)) i_sync (
    .clk     (clk),
    .rstN    (rstN),
    .rawN    (rawN),
    .syncOut (syncOut)
  );

  lpm_fsm i_fsm (
    .clk        (clk),
    .rstN       (rstN),
    .pwrGood    (pwrGood),
    .sleepFall  (syncOut[IN_SLEEP]),
    .wakeFall   (syncOut[IN_WAKE]),
    .ulpSelLvlN (syncOut[IN_ULP]),
    .curState   (curState),
    .strobe     (strobe),
    .buckEn     (buckEn),
    .ldoEn      (ldoEn)
  );

  lpm_wave #(
    .TICK_DIV   (TICK_DIV),
    .LED_PERIOD (LED_PERIOD),
    .LED_ON     (LED_ON),
    .KA_ON      (KA_ON),
    .KA_OFF     (KA_OFF)
  ) i_wave (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .ledWave (ledOn),
    .kaWave  (keepAliveEn)
  );

endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk
  import lpm_pkg::*;
(
  input logic      clk,
  input logic      rstN,
  input logic      pwrGood,
  input logic      sleepFall,
  input logic      wakeFall,
  input logic      ulpLvlN,
  input lpmState_e curState,
  input logic      buckEn,
  input logic      ledOn,
  input logic      keepAliveEn
);

  // R1: sleep edge in wake picks the rest state from the select level
  a_r1_enter_sleep: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_WAKE && pwrGood && sleepFall && ulpLvlN) |=> (curState == ST_SLEEP));
  a_r1_enter_ulp: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_WAKE && pwrGood && sleepFall && !ulpLvlN) |=> (curState == ST_ULP));

  // R2: outside wake, only a wake edge or power loss moves the state
  a_r2_sleep_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (curState != ST_WAKE && pwrGood && !wakeFall) |=> $stable(curState));

  // R3: wake edge returns to wake
  a_r3_wake_return: assert property (@(posedge clk) disable iff (!rstN)
    (curState != ST_WAKE && wakeFall) |=> (curState == ST_WAKE));

  // R4 / R5: LED blinking and regulators are never on together
  a_r5_led_excl: assert property (@(posedge clk) disable iff (!rstN)
    ledOn |-> !buckEn);

  // R6: keep-alive only in the ultra-low-power state
  a_r6_ka_ulp_only: assert property (@(posedge clk) disable iff (!rstN)
    keepAliveEn |-> (curState == ST_ULP));

  // R7: power loss silences all outputs and returns to wake
  a_r7_pg_outputs: assert property (@(posedge clk) disable iff (!rstN)
    !pwrGood |-> (!buckEn && !ledOn && !keepAliveEn));
  a_r7_pg_wake: assert property (@(posedge clk) disable iff (!rstN)
    !pwrGood |=> (curState == ST_WAKE));

endmodule

bind lpm_ctrl lpm_ctrl_chk i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .pwrGood     (pwrGood),
  .sleepFall   (syncOut[lpm_pkg::IN_SLEEP]),
  .wakeFall    (syncOut[lpm_pkg::IN_WAKE]),
  .ulpLvlN     (syncOut[lpm_pkg::IN_ULP]),
  .curState    (curState),
  .buckEn      (buckEn),
  .ledOn       (ledOn),
  .keepAliveEn (keepAliveEn)
);

// File: tb/test_lpm_ctrl.sv
`timescale 1ns/1ps
module test_lpm_ctrl;

  localparam int TICK_DIV = 2, LED_PERIOD = 8, LED_ON = 2, KA_ON = 5, KA_OFF = 7;
  localparam int LED_CYC = LED_PERIOD * TICK_DIV;
  localparam int LED_HI  = LED_ON * TICK_DIV;
  localparam int KA_CYC  = (KA_ON + KA_OFF) * TICK_DIV;
  localparam int KA_HI   = KA_ON * TICK_DIV;

  // op: 0 sleep edge, 1 wake edge, 2 power-good drop; expected value 2 = not checked
  localparam int    NROW = 11;
  localparam int    OP_T  [NROW] = '{0, 0, 1, 0, 0, 1, 1, 0, 2, 0, 1};
  localparam int    ULP_T [NROW] = '{1, 0, 1, 0, 1, 1, 1, 1, 1, 0, 1};
  localparam int    BK_T  [NROW] = '{0, 0, 1, 0, 0, 1, 1, 0, 0, 0, 1};
  localparam int    LED_T [NROW] = '{1, 2, 0, 1, 2, 0, 0, 1, 0, 1, 0};
  localparam int    KA_T  [NROW] = '{0, 0, 0, 1, 2, 0, 0, 0, 0, 1, 0};
  localparam string REQ_T [NROW] = '{"R1", "R2", "R3", "R1", "R2", "R3",
                                     "R3", "R1", "R7", "R6", "R4"};

  logic clk = 1'b0, rstN = 1'b0, pwrGood = 1'b1;
  logic sleepReqN = 1'b1, wakeReqN = 1'b1, ulpSelN = 1'b1;
  logic buckEn, ldoEn, ledOn, keepAliveEn;
  int   checks = 0, errors = 0;

  always #5 clk = ~clk;

  lpm_ctrl #(.TICK_DIV(TICK_DIV), .LED_PERIOD(LED_PERIOD), .LED_ON(LED_ON),
             .KA_ON(KA_ON), .KA_OFF(KA_OFF)) i_lpm_ctrl (
    .clk(clk), .rstN(rstN), .pwrGood(pwrGood), .sleepReqN(sleepReqN),
    .wakeReqN(wakeReqN), .ulpSelN(ulpSelN), .buckEn(buckEn), .ldoEn(ldoEn),
    .ledOn(ledOn), .keepAliveEn(keepAliveEn));

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic checkOuts(input string req, input int b, input int l, input int k);
    check(req, "buckEn", int'(buckEn), b);
    check(req, "ldoEn", int'(ldoEn), b);
    if (l != 2) check(req, "ledOn", int'(ledOn), l);
    if (k != 2) check(req, "keepAliveEn", int'(keepAliveEn), k);
  endtask

  // drives a sleep edge and stops at the negedge after the state update
  task automatic sleepEdge(input logic ulp);
    @(negedge clk) ulpSelN = ulp;
    repeat (3) @(negedge clk);
    sleepReqN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wakeEdge();
    @(negedge clk) wakeReqN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic releaseAll();
    sleepReqN = 1'b1;
    wakeReqN  = 1'b1;
    pwrGood   = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  // samples one waveform cycle by cycle, starting at the first cycle after entry
  task automatic checkWave(input string req, input bit ulpMode, input int n);
    int badLed = 0, badKa = 0;
    for (int j = 0; j < n; j++) begin
      if (int'(ledOn) != int'((j % LED_CYC) < LED_HI)) badLed++;
      if (int'(keepAliveEn) != (ulpMode ? int'((j % KA_CYC) < KA_HI) : 0)) badKa++;
      if (j == 2) sleepReqN = 1'b1;
      @(negedge clk);
    end
    check(req, "ledOn waveform mismatches", badLed, 0);
    check(ulpMode ? "R6" : req, "keepAliveEn waveform mismatches", badKa, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    // R8: reset state, no transition from idle-high inputs
    checkOuts("R8", 1, 0, 0);

    for (int r = 0; r < NROW; r++) begin
      case (OP_T[r])
        0: sleepEdge(ULP_T[r] != 0);
        1: wakeEdge();
        default: begin
          @(negedge clk) pwrGood = 1'b0;
          repeat (3) @(posedge clk);
          @(negedge clk);
        end
      endcase
      checkOuts(REQ_T[r], BK_T[r], LED_T[r], KA_T[r]);
      releaseAll();
    end

    // R5: light-sleep LED waveform from entry
    sleepEdge(1'b1);
    checkWave("R5", 1'b0, 2 * LED_CYC + 5);
    wakeEdge();
    check("R3", "buckEn after wake", int'(buckEn), 1);
    releaseAll();

    // R7: power loss mid ultra-low-power, then sleep edge while power is low
    sleepEdge(1'b0);
    repeat (7) @(negedge clk);
    sleepReqN = 1'b1;
    pwrGood = 1'b0;
    @(negedge clk);
    check("R7", "ledOn with power low", int'(ledOn), 0);
    sleepReqN = 1'b0;
    repeat (6) @(negedge clk);
    pwrGood = 1'b1;
    repeat (2) @(negedge clk);
    check("R7", "buckEn after power restored", int'(buckEn), 1);
    releaseAll();

    // R6: after the cleared timers, ultra-low-power waveforms start fresh
    sleepEdge(1'b0);
    checkWave("R5", 1'b1, 2 * KA_CYC + 3);
    wakeEdge();
    checkOuts("R4", 1, 0, 0);
    releaseAll();

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule